// File: doc/BRIEF.md
# Interrupt Acknowledge and Completion Tracker

This block keeps the acknowledge and end-of-interrupt state for one processor. It sits between a pending-interrupt arbiter and the processor interface. When the processor acknowledges, the block takes the highest pending interrupt ID offered by the arbiter. It decides whether that ID may be handed out, given the running priority and the group and security rules. It answers with the ID or with a spurious code. On success it makes the interrupt the running one and pulses a clear request for its pending state.

Nested interrupts are recorded as a chain of "previously active" links, with one link per interrupt ID. Completing the running interrupt restores its predecessor. A completion may also name an interrupt lower in the chain. In that case a small walker steps down the chain one link per clock and unlinks that interrupt, so that later completions skip it. While the walker runs, the block reports busy and holds back new acknowledge and completion requests.

Top module: `irq_active_tracker`

## Requirements
- R1: After reset, and whenever no interrupt is running, `run_id` is 1023 and `run_prio` is 256 (bit PRIO_W set). While an interrupt runs, `run_prio` equals that interrupt's priority from `irq_prio` and is below 256.
- R2: An acknowledge whose pending ID is 1023 or at or above NUM_IRQ, or whose pending priority is not strictly below `run_prio`, answers 1023. It changes neither `run_id`, `run_prio` nor the links, and `pend_clr` stays low.
- R3: With `groups_en` high, two cases are hidden. A group-0 pending interrupt (its `irq_group` bit is 0) seen by a non-secure acknowledge answers 1023. A group-1 pending interrupt seen by a secure acknowledge answers 1022 unless `ack_ctl` is high. A hidden answer changes no state. With `groups_en` low, nothing is hidden.
- R4: A successful acknowledge answers the pending ID and pulses `pend_clr`. The old `run_id` is stored as the new interrupt's predecessor link, and the new interrupt becomes the running one.
- R5: An end-of-interrupt is ignored in three cases: the ID is at or above NUM_IRQ, no interrupt is running, or `groups_en` is high and a non-secure access names a group-0 interrupt.
- R6: An end-of-interrupt naming the running ID sets `run_id` to that interrupt's stored predecessor. `run_prio` follows per R1.
- R7: An end-of-interrupt naming any other ID walks the chain from the running interrupt. It looks for the node whose link equals that ID and replaces that link with the completed interrupt's own link. The walk stops at a link of 1023, or after NUM_IRQ nodes, and then changes nothing.
- R8: Only bits 9:0 of `eoi_data` form the ID. Bits 15:10 are ignored.
- R9: A request is taken on a clock edge where `busy` is low, and an end-of-interrupt takes precedence over an acknowledge requested in the same cycle. The acknowledge answer (`ack_done`, `ack_id`, `pend_clr`) and the new `run_id` appear one cycle after the take. A chain walk raises `busy` one cycle after its take and holds it for one cycle per node examined.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| groups_en | input | 1 | Group and security hiding rules apply |
| ack_ctl | input | 1 | Lets secure acknowledges take group-1 interrupts |
| irq_prio | input | NUM_IRQ*PRIO_W | Priority per interrupt; entry i at bits i*PRIO_W upward |
| irq_group | input | NUM_IRQ | Group per interrupt (0 or 1) |
| pend_id | input | 10 | Highest pending ID from the arbiter, 1023 when none |
| ack_req | input | 1 | Acknowledge request, held until taken |
| ack_secure | input | 1 | Acknowledge is a secure access |
| eoi_req | input | 1 | End-of-interrupt request, held until taken |
| eoi_secure | input | 1 | End-of-interrupt is a secure access |
| eoi_data | input | 16 | End-of-interrupt value; ID in bits 9:0 |
| ack_done | output | 1 | One-cycle pulse: acknowledge answer valid |
| ack_id | output | 10 | Acknowledge answer: ID, 1022 or 1023 |
| pend_clr | output | 1 | One-cycle pulse: clear pending state of `ack_id` |
| run_id | output | 10 | Running interrupt ID, 1023 when none |
| run_prio | output | PRIO_W+1 | Running priority, 256 when none |
| busy | output | 1 | Chain walk in progress; requests wait |

## Verification
The bench builds the block with NUM_IRQ at 16 and PRIO_W at 8. With 16 interrupts, a chain as deep as the whole ID space can be built and unlinked from its far end, so the walk length limit is reached. Completion IDs from 16 to 1022, and upper `eoi_data` bits, also come within easy reach of both directed and random stimulus. Each ID gets its own priority and alternating group, so every hiding case and every preemption reject can be produced from a fixed table.

// File: rtl/irq_trk_pkg.sv
// Shared constants and decision codes for the acknowledge/completion tracker.
// Assumes the interrupt ID space is 10 bits wide.
package irq_trk_pkg;
    localparam int ID_W = 10;
    localparam logic [ID_W-1:0] ID_NONE   = 10'd1023;
    localparam logic [ID_W-1:0] ID_HID_G1 = 10'd1022;

    typedef enum logic [2:0] {
        ACK_TAKEN,
        ACK_EMPTY,
        ACK_LOW_PRIO,
        ACK_HIDE_NS,
        ACK_HIDE_G1
    } ack_verdict_e;

    typedef enum logic [1:0] {
        EOI_DROP,
        EOI_POP,
        EOI_WALK
    } eoi_kind_e;
endpackage

// File: rtl/irq_trk_ack_judge.sv
// Decides the answer to an acknowledge from the offered pending interrupt.
// Purely combinational; assumes pend_prio/pend_group are valid when in_range.
module irq_trk_ack_judge
    import irq_trk_pkg::*;
#(
    parameter int PRIO_W = 8
) (
    input  logic [ID_W-1:0]   pend_id,
    input  logic              in_range,
    input  logic [PRIO_W-1:0] pend_prio,
    input  logic              pend_group,
    input  logic              groups_en,
    input  logic              ack_ctl,
    input  logic              secure,
    input  logic [PRIO_W:0]   run_prio,
    output ack_verdict_e      verdict,
    output logic [ID_W-1:0]   resp_id
);
    // Ordered checks: empty, security hiding, then preemption level.
    always_comb begin
        if (!in_range) begin
            verdict = ACK_EMPTY;
            resp_id = ID_NONE;
        end else if (groups_en && !pend_group && !secure) begin
            verdict = ACK_HIDE_NS;
            resp_id = ID_NONE;
        end else if (groups_en && pend_group && secure && !ack_ctl) begin
            verdict = ACK_HIDE_G1;
            resp_id = ID_HID_G1;
        end else if ({1'b0, pend_prio} >= run_prio) begin
            verdict = ACK_LOW_PRIO;
            resp_id = ID_NONE;
        end else begin
            verdict = ACK_TAKEN;
            resp_id = pend_id;
        end
    end
endmodule

// File: rtl/irq_trk_eoi_judge.sv
// Classifies an end-of-interrupt as ignored, a pop of the running
// interrupt, or an unlink that needs a chain walk. Combinational.
module irq_trk_eoi_judge
    import irq_trk_pkg::*;
(
    input  logic [ID_W-1:0] eoi_id,
    input  logic            in_range,
    input  logic            eoi_group,
    input  logic            groups_en,
    input  logic            secure,
    input  logic [ID_W-1:0] run_id,
    output eoi_kind_e       kind
);
    // Drop conditions first, then match against the running ID.
    always_comb begin
        if (!in_range || run_id == ID_NONE ||
            (groups_en && !secure && !eoi_group))
            kind = EOI_DROP;
        else if (eoi_id == run_id)
            kind = EOI_POP;
        else
            kind = EOI_WALK;
    end
endmodule

// File: rtl/irq_trk_link_store.sv
// Per-interrupt predecessor link registers, reset to "none".
// One write port, three asynchronous read ports. Assumes callers only
// use read data for indices below NUM_IRQ.
module irq_trk_link_store
    import irq_trk_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int IDX_W   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [ID_W-1:0]  wr_val,
    input  logic [IDX_W-1:0] rd_idx_a,
    input  logic [IDX_W-1:0] rd_idx_b,
    input  logic [IDX_W-1:0] rd_idx_c,
    output logic [ID_W-1:0]  rd_a,
    output logic [ID_W-1:0]  rd_b,
    output logic [ID_W-1:0]  rd_c
);
    logic [ID_W-1:0] links [NUM_IRQ];

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_entry
        // Holds the predecessor of interrupt g while it is active.
        always_ff @(posedge clk) begin
            if (!rst_n)
                links[g] <= ID_NONE;
            else if (wr_en && wr_idx == IDX_W'(g))
                links[g] <= wr_val;
        end
    end

    assign rd_a = links[rd_idx_a];
    assign rd_b = links[rd_idx_b];
    assign rd_c = links[rd_idx_c];
endmodule

// File: rtl/irq_trk_chain_walker.sv
// Walks the active chain one node per clock to unlink a completed
// interrupt that is not the running one. Assumes start is only pulsed
// while idle and that the chain does not change during a walk.
module irq_trk_chain_walker
    import irq_trk_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int IDX_W   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [ID_W-1:0]  start_node,
    input  logic [ID_W-1:0]  start_tgt,
    output logic [IDX_W-1:0] cur_idx,
    output logic [IDX_W-1:0] tgt_idx,
    input  logic [ID_W-1:0]  cur_link,
    input  logic [ID_W-1:0]  tgt_link,
    output logic             busy,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [ID_W-1:0]  wr_val
);
    localparam int STEP_W = $clog2(NUM_IRQ + 1);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_IRQ - 1);

    logic [ID_W-1:0]   cur;
    logic [ID_W-1:0]   tgt;
    logic [STEP_W-1:0] steps;
    logic              found;
    logic              stop_now;

    assign cur_idx  = cur[IDX_W-1:0];
    assign tgt_idx  = tgt[IDX_W-1:0];
    assign found    = (cur_link == tgt);
    assign stop_now = found || cur_link == ID_NONE || steps == LAST_STEP;
    assign wr_en    = busy && found;
    assign wr_idx   = cur_idx;
    assign wr_val   = tgt_link;

    // Walk state: load on start, advance one link per clock until stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cur   <= ID_NONE;
            tgt   <= ID_NONE;
            steps <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            cur   <= start_node;
            tgt   <= start_tgt;
            steps <= '0;
        end else if (busy) begin
            if (stop_now)
                busy <= 1'b0;
            else begin
                cur   <= cur_link;
                steps <= steps + 1'b1;
            end
        end
    end

    a_r7_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (steps <= LAST_STEP));
    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start);
    a_r7_walk_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && stop_now) |=> !busy);
endmodule

// File: rtl/irq_active_tracker.sv
// Per-processor acknowledge / end-of-interrupt tracker with a linked
// chain of previously active interrupts. Assumes pend_id comes from an
// external arbiter and that requesters hold a request until busy is low.
module irq_active_tracker
    import irq_trk_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int PRIO_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      groups_en,
    input  logic                      ack_ctl,
    input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio,
    input  logic [NUM_IRQ-1:0]        irq_group,
    input  logic [9:0]                pend_id,
    input  logic                      ack_req,
    input  logic                      ack_secure,
    input  logic                      eoi_req,
    input  logic                      eoi_secure,
    input  logic [15:0]               eoi_data,
    output logic                      ack_done,
    output logic [9:0]                ack_id,
    output logic                      pend_clr,
    output logic [9:0]                run_id,
    output logic [PRIO_W:0]           run_prio,
    output logic                      busy
);
    localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
    localparam logic [PRIO_W:0]  IDLE_PRIO = {1'b1, {PRIO_W{1'b0}}};
    localparam logic [ID_W-1:0]  ID_LIMIT  = ID_W'(NUM_IRQ);

    logic [PRIO_W-1:0] prio_tab [NUM_IRQ];
    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_prio
        assign prio_tab[g] = irq_prio[g*PRIO_W +: PRIO_W];
    end

    // Request takes and decoded identifiers.
    logic            ack_take, eoi_take;
    logic [ID_W-1:0] eoi_id;
    logic            pend_ok, eoi_ok;
    assign eoi_take = eoi_req && !busy;
    assign ack_take = ack_req && !busy && !eoi_req;
    assign eoi_id   = eoi_data[ID_W-1:0];
    assign pend_ok  = pend_id < ID_LIMIT;
    assign eoi_ok   = eoi_id < ID_LIMIT;

    ack_verdict_e    verdict;
    logic [ID_W-1:0] resp_id;
    eoi_kind_e       eoi_kind;

    irq_trk_ack_judge #(.PRIO_W(PRIO_W)) u_ack_judge (
        .pend_id    (pend_id),
        .in_range   (pend_ok),
        .pend_prio  (prio_tab[pend_id[IDX_W-1:0]]),
        .pend_group (irq_group[pend_id[IDX_W-1:0]]),
        .groups_en  (groups_en),
        .ack_ctl    (ack_ctl),
        .secure     (ack_secure),
        .run_prio   (run_prio),
        .verdict    (verdict),
        .resp_id    (resp_id)
    );

    irq_trk_eoi_judge u_eoi_judge (
        .eoi_id    (eoi_id),
        .in_range  (eoi_ok),
        .eoi_group (irq_group[eoi_id[IDX_W-1:0]]),
        .groups_en (groups_en),
        .secure    (eoi_secure),
        .run_id    (run_id),
        .kind      (eoi_kind)
    );

    // Link storage wiring.
    logic             ack_win;
    logic             walk_start;
    logic             lk_wr_en, wk_wr_en;
    logic [IDX_W-1:0] lk_wr_idx, wk_wr_idx;
    logic [ID_W-1:0]  lk_wr_val, wk_wr_val;
    logic [IDX_W-1:0] wk_cur_idx, wk_tgt_idx;
    logic [ID_W-1:0]  pred_id, wk_cur_link, wk_tgt_link;
    logic [PRIO_W:0]  pred_prio;

    assign ack_win    = ack_take && verdict == ACK_TAKEN;
    assign walk_start = eoi_take && eoi_kind == EOI_WALK;

    // Write mux: an acknowledge and a walk never coincide.
    always_comb begin
        if (ack_win) begin
            lk_wr_en  = 1'b1;
            lk_wr_idx = pend_id[IDX_W-1:0];
            lk_wr_val = run_id;
        end else begin
            lk_wr_en  = wk_wr_en;
            lk_wr_idx = wk_wr_idx;
            lk_wr_val = wk_wr_val;
        end
    end

    irq_trk_link_store #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_links (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (lk_wr_en),
        .wr_idx   (lk_wr_idx),
        .wr_val   (lk_wr_val),
        .rd_idx_a (run_id[IDX_W-1:0]),
        .rd_idx_b (wk_cur_idx),
        .rd_idx_c (wk_tgt_idx),
        .rd_a     (pred_id),
        .rd_b     (wk_cur_link),
        .rd_c     (wk_tgt_link)
    );

    irq_trk_chain_walker #(.NUM_IRQ(NUM_IRQ), .IDX_W(IDX_W)) u_walker (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (walk_start),
        .start_node (run_id),
        .start_tgt  (eoi_id),
        .cur_idx    (wk_cur_idx),
        .tgt_idx    (wk_tgt_idx),
        .cur_link   (wk_cur_link),
        .tgt_link   (wk_tgt_link),
        .busy       (busy),
        .wr_en      (wk_wr_en),
        .wr_idx     (wk_wr_idx),
        .wr_val     (wk_wr_val)
    );

    // Priority to restore when the running interrupt is popped.
    assign pred_prio = (pred_id == ID_NONE) ? IDLE_PRIO
                                            : {1'b0, prio_tab[pred_id[IDX_W-1:0]]};

    // Running state and registered acknowledge answer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_id   <= ID_NONE;
            run_prio <= IDLE_PRIO;
            ack_done <= 1'b0;
            ack_id   <= ID_NONE;
            pend_clr <= 1'b0;
        end else begin
            ack_done <= ack_take;
            pend_clr <= ack_win;
            if (ack_take)
                ack_id <= resp_id;
            if (ack_win) begin
                run_id   <= pend_id;
                run_prio <= {1'b0, prio_tab[pend_id[IDX_W-1:0]]};
            end else if (eoi_take && eoi_kind == EOI_POP) begin
                run_id   <= pred_id;
                run_prio <= pred_prio;
            end
        end
    end

    a_r1_idle_prio: assert property (@(posedge clk) disable iff (!rst_n)
        (run_id == ID_NONE) |-> (run_prio == IDLE_PRIO));
    a_r1_active_prio: assert property (@(posedge clk) disable iff (!rst_n)
        (run_id != ID_NONE) |-> (run_prio < IDLE_PRIO));
    a_r4_clr_is_running: assert property (@(posedge clk) disable iff (!rst_n)
        pend_clr |-> (ack_done && ack_id == run_id));
    a_r3_refusal_code: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_done && !pend_clr) |-> (ack_id == ID_NONE || ack_id == ID_HID_G1));
    a_r9_walk_holds_run: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(run_id));
    a_r9_no_ack_in_walk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !ack_done);
    a_r8_range_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_req && !busy && eoi_data[15:10] != 6'd0 && eoi_id >= ID_LIMIT)
            |=> $stable(run_id));
endmodule

// File: tb/test_irq_active_tracker.sv
`timescale 1ns/1ps
module test_irq_active_tracker;
    localparam int N  = 16;
    localparam int PW = 8;
    localparam int NONE = 1023;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              groups_en = 1'b0;
    logic              ack_ctl = 1'b0;
    logic [N*PW-1:0]   irq_prio;
    logic [N-1:0]      irq_group;
    logic [9:0]        pend_id = 10'd1023;
    logic              ack_req = 1'b0;
    logic              ack_secure = 1'b0;
    logic              eoi_req = 1'b0;
    logic              eoi_secure = 1'b0;
    logic [15:0]       eoi_data = 16'd0;
    logic              ack_done, pend_clr, busy;
    logic [9:0]        ack_id, run_id;
    logic [PW:0]       run_prio;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    irq_active_tracker #(.NUM_IRQ(N), .PRIO_W(PW)) i_irq_active_tracker (
        .clk(clk), .rst_n(rst_n), .groups_en(groups_en), .ack_ctl(ack_ctl),
        .irq_prio(irq_prio), .irq_group(irq_group), .pend_id(pend_id),
        .ack_req(ack_req), .ack_secure(ack_secure), .eoi_req(eoi_req),
        .eoi_secure(eoi_secure), .eoi_data(eoi_data), .ack_done(ack_done),
        .ack_id(ack_id), .pend_clr(pend_clr), .run_id(run_id),
        .run_prio(run_prio), .busy(busy)
    );

    // Priority table: lower ID is more urgent; odd IDs are group 1.
    function automatic int prio_of(int id);
        return 8 * id + 16;
    endfunction

    initial begin
        for (int i = 0; i < N; i++) begin
            irq_prio[i*PW +: PW] = PW'(prio_of(i));
            irq_group[i] = i[0];
        end
    end

    // ---------------- reference model ----------------
    int    m_link [N];
    int    m_run, m_rprio, m_busy_cnt, m_ack_id;
    bit    m_ack_done, m_clr;
    string m_tag = "R1";

    task automatic model_ack();
        int id = int'(pend_id);
        m_ack_done = 1'b1;
        if (id >= N) begin
            m_ack_id = NONE; m_tag = "R2";
        end else if (groups_en && !irq_group[id] && !ack_secure) begin
            m_ack_id = NONE; m_tag = "R3";
        end else if (groups_en && irq_group[id] && ack_secure && !ack_ctl) begin
            m_ack_id = 1022; m_tag = "R3";
        end else if (prio_of(id) >= m_rprio) begin
            m_ack_id = NONE; m_tag = "R2";
        end else begin
            m_link[id] = m_run; m_run = id; m_rprio = prio_of(id);
            m_ack_id = id; m_clr = 1'b1; m_tag = "R4";
        end
    endtask

    task automatic model_eoi();
        int id = int'(eoi_data) & 1023;
        bit hi = (eoi_data[15:10] != 0);
        if (id >= N || m_run == NONE || (groups_en && !eoi_secure && !irq_group[id])) begin
            m_tag = hi ? "R8" : "R5";
        end else if (id == m_run) begin
            m_run = m_link[id];
            m_rprio = (m_run == NONE) ? 256 : prio_of(m_run);
            m_tag = hi ? "R8" : "R6";
        end else begin
            int cur = m_run;
            int n = 0;
            while (1) begin
                int nx;
                n++;
                nx = m_link[cur];
                if (nx == id) begin m_link[cur] = m_link[id]; break; end
                if (nx == NONE || n == N) break;
                cur = nx;
            end
            m_busy_cnt = n;
            m_tag = "R7";
        end
    endtask

    // Model advances on the same edges as the design.
    always @(posedge clk) begin
        m_ack_done = 1'b0;
        m_clr = 1'b0;
        if (!rst_n) begin
            for (int i = 0; i < N; i++) m_link[i] = NONE;
            m_run = NONE; m_rprio = 256; m_busy_cnt = 0; m_ack_id = NONE;
            m_tag = "R1";
        end else if (m_busy_cnt > 0) begin
            m_busy_cnt--;
            if (ack_req || eoi_req) m_tag = "R9";
        end else if (eoi_req) begin
            model_eoi();
            if (ack_req) m_tag = "R9";
        end else if (ack_req) begin
            model_ack();
        end
    end

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Compare every output away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check(m_tag, "run_id", int'(run_id), m_run);
            check(m_tag, "run_prio", int'(run_prio), m_rprio);
            check("R9", "busy", int'(busy), int'(m_busy_cnt > 0));
            check(m_tag, "ack_done", int'(ack_done), int'(m_ack_done));
            check(m_tag, "pend_clr", int'(pend_clr), int'(m_clr));
            if (m_ack_done) check(m_tag, "ack_id", int'(ack_id), m_ack_id);
        end
    end

    // ---------------- stimulus ----------------
    task automatic ack_op(int pid, bit sec);
        @(negedge clk);
        pend_id = 10'(pid); ack_secure = sec; ack_req = 1'b1;
        while (busy || eoi_req) @(negedge clk);
        @(negedge clk);
        ack_req = 1'b0;
    endtask

    task automatic eoi_op(int val, bit sec);
        @(negedge clk);
        eoi_data = 16'(val); eoi_secure = sec; eoi_req = 1'b1;
        while (busy) @(negedge clk);
        @(negedge clk);
        eoi_req = 1'b0;
    endtask

    task automatic drain();
        while (m_run != NONE) eoi_op(m_run, 1'b1);
        while (busy) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);          // R1 reset state compared here

        ack_op(NONE, 1'b1);                 // R2 nothing pending
        ack_op(20, 1'b1);                   // R2 out of range
        ack_op(10, 1'b1);                   // R4
        ack_op(5, 1'b1);
        ack_op(2, 1'b1);
        ack_op(7, 1'b1);                    // R2 not more urgent
        ack_op(1, 1'b1);                    // chain 1-2-5-10
        eoi_op(5, 1'b1);                    // R7 unlink from middle
        ack_op(0, 1'b1);                    // R9 waits out the walk
        eoi_op(16'hFC00, 1'b1);             // R8 upper bits dropped, pops 0
        eoi_op(1, 1'b1);                    // R6
        eoi_op(2, 1'b1);                    // R6 skips 5
        eoi_op(10, 1'b1);                   // R1 back to idle
        eoi_op(3, 1'b1);                    // R5 nothing running
        ack_op(10, 1'b1);
        ack_op(4, 1'b1);
        eoi_op(17, 1'b1);                   // R5 out of range
        eoi_op(6, 1'b1);                    // R7 not in chain
        groups_en = 1'b1;
        ack_op(2, 1'b0);                    // R3 group 0 hidden from non-secure
        ack_op(3, 1'b1);                    // R3 answers 1022
        ack_ctl = 1'b1;
        ack_op(3, 1'b1);                    // R3 allowed with ack_ctl
        eoi_op(4, 1'b0);                    // R5 non-secure on group 0
        eoi_op(3, 1'b0);                    // R6 non-secure on group 1
        // R9 simultaneous requests: completion first
        @(negedge clk);
        pend_id = 10'd1; ack_secure = 1'b1; ack_req = 1'b1;
        eoi_data = 16'd4; eoi_secure = 1'b1; eoi_req = 1'b1;
        @(negedge clk);
        eoi_req = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
        ack_req = 1'b0;
        groups_en = 1'b0;
        drain();
        // Deep chain, then unlink its far end (R7 length limit region).
        for (int i = N - 1; i >= 0; i--) ack_op(i, 1'b1);
        eoi_op(N - 1, 1'b1);
        drain();
        // Mixed random traffic.
        for (int k = 0; k < 400; k++) begin
            int r = int'($urandom_range(0, 9));
            groups_en = ($urandom_range(0, 3) == 0);
            ack_ctl = $urandom_range(0, 1) != 0;
            if (r < 5)
                ack_op(int'($urandom_range(0, 19)), $urandom_range(0, 1) != 0);
            else if (r < 8 && m_run != NONE)
                eoi_op(m_run | (int'($urandom_range(0, 63)) << 10), $urandom_range(0, 1) != 0);
            else
                eoi_op(int'($urandom_range(0, 65535)), $urandom_range(0, 1) != 0);
        end
        repeat (N + 4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule